// File: doc/BRIEF.md
# ATAPI PIO Packet Data-Phase Controller

This block is the device end of a packet-command read carried out by programmed I/O. A host writes a byte-count limit and a PACKET command code into a small task-file register set. It then writes a 12-byte command packet as six 16-bit words and collects the requested 2048-byte logical blocks by reading a 16-bit data register. The block splits the transfer into bursts. No burst is larger than the host's limit with bit 0 cleared, or larger than the internal burst buffer. Each burst is announced by an interrupt and by the DRQ status bit. One more interrupt marks the end of the command.

Block data comes from a simple word-read port. The block issues one word request at a time, gathers a full burst into a block-RAM buffer while it shows BSY, and then serves the host from that buffer. A status-register read clears the pending interrupt, so the host sequence is: wait for the interrupt, read status, then read the burst's words.

Top module: `atapi_pio_ctrl`

## Requirements
- R1: After reset, `intrq` is low and a status read (address 7) returns 0x40. The status bits are BSY=bit 7, DRDY=bit 6, DF=bit 5, DRQ=bit 3 and ERR=bit 0. DF and ERR always read 0.
- R2: Writing 0xA0 to address 7 while idle latches the byte-count limit. The low byte comes from address 4 and the high byte from address 5. Status then reads 0xC0 for one cycle, followed by 0x48 with no interrupt. Any other command code written while idle has no effect.
- R3: The packet is six writes to address 0, each word holding packet bytes 2i (low half) and 2i+1 (high half). Bytes 2..5 are the LBA and bytes 7..8 are the block count, both most significant byte first.
- R4: The host receives count × 1024 words. Word k of the transfer comes from source word address LBA × 1024 + k, and words arrive in order.
- R5: The burst size in words is min(remaining words, clamp(limit >> 1)). The clamp raises 0 to 1 and cuts anything above the buffer depth (1024 words by default) to the buffer depth.
- R6: When a burst is ready, `intrq` rises and status reads 0x48.
- R7: After the last burst has been read, `intrq` rises once more and status reads 0x40.
- R8: A status read clears `intrq` one cycle later. If a new interrupt is raised in the same cycle, the interrupt stays set.
- R9: While a burst is being fetched, status reads 0xC0 and data-register reads return 0 without consuming data. Read data appears on `host_rdata` in the cycle after the read strobe.
- R10: A block count of zero ends the command right after the sixth packet word, with only the completion interrupt.
- R11: BSY and DRQ are never set together, and `src_req` is only issued while BSY is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 3 | Register address: 0 data, 4 limit low, 5 limit high, 7 command/status |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid the cycle after the strobe |
| intrq | output | 1 | Interrupt request |
| src_req | output | 1 | One-cycle word request to the block source |
| src_addr | output | 42 | Source word address |
| src_valid | input | 1 | Source response strobe |
| src_data | input | 16 | Source response word |

## Verification
The delicate overlap is a status read that lands in the same cycle as an interrupt raise. This happens when the host polls status and the final word of a burst arrives in that very cycle. The bench provokes it by holding the status read strobe high on every cycle while a multi-burst transfer with a small limit is fetched, so that one read falls on the raise edge. It judges the result by counting every rising interrupt seen between clock edges against the expected number, which is the number of bursts plus one. If the clear won over the raise, an interrupt would be lost from the count.

// File: rtl/atapi_pio_pkg.sv
package atapi_pio_pkg;
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_LIM_LO = 3'd4;
  localparam logic [2:0] A_LIM_HI = 3'd5;
  localparam logic [2:0] A_CMD = 3'd7;
  localparam logic [7:0] OP_PACKET = 8'hA0;
  localparam int ST_BSY = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DRQ = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_PKT,
    PH_FETCH,
    PH_XFER
  } phase_t;
endpackage

// File: rtl/atapi_pkt_capture.sv
module atapi_pkt_capture (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        wr,
  input  logic [15:0] wdata,
  output logic        done,
  output logic [31:0] lba,
  output logic [15:0] cnt
);
  logic [2:0]  idx_q;
  logic [31:0] lba_q;
  logic [7:0]  cnt_hi_q;
  logic [7:0]  cnt_lo_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx_q <= '0;
    end else if (wr) begin
      idx_q <= (idx_q == 3'd5) ? 3'd0 : idx_q + 3'd1;
    end
  end

  // packet bytes: word i = {byte 2i+1, byte 2i}; LBA and count big-endian
  always_ff @(posedge clk) begin
    if (rst) begin
      lba_q    <= '0;
      cnt_hi_q <= '0;
      cnt_lo_q <= '0;
    end else if (wr) begin
      case (idx_q)
        3'd1: lba_q[31:16] <= {wdata[7:0], wdata[15:8]};
        3'd2: lba_q[15:0]  <= {wdata[7:0], wdata[15:8]};
        3'd3: cnt_hi_q     <= wdata[15:8];
        3'd4: cnt_lo_q     <= wdata[7:0];
        default: ;
      endcase
    end
  end

  assign done = wr && (idx_q == 3'd5);
  assign lba  = lba_q;
  assign cnt  = {cnt_hi_q, cnt_lo_q};
endmodule

// File: rtl/atapi_burst_plan.sv
module atapi_burst_plan #(
  parameter int REM_W  = 26,
  parameter int BUF_LG = 10
) (
  input  logic [REM_W-1:0]  rem,
  input  logic [14:0]       lim_words,
  output logic [BUF_LG:0]   words
);
  localparam int BUF_WORDS = 1 << BUF_LG;

  logic [31:0] lim_c;
  logic [31:0] rem_c;

  always_comb begin
    lim_c = 32'(lim_words);
    if (lim_c == 32'd0) lim_c = 32'd1;
    else if (lim_c > 32'(BUF_WORDS)) lim_c = 32'(BUF_WORDS);
    rem_c = 32'(rem);
    words = (rem_c < lim_c) ? (BUF_LG + 1)'(rem_c) : (BUF_LG + 1)'(lim_c);
  end
endmodule

// File: rtl/atapi_burst_buf.sv
module atapi_burst_buf #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/atapi_pio_ctrl.sv
module atapi_pio_ctrl #(
  parameter int BLK_LG = 10,
  parameter int BUF_LG = 10,
  localparam int SRC_AW = 32 + BLK_LG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [2:0]        host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              intrq,
  output logic              src_req,
  output logic [SRC_AW-1:0] src_addr,
  input  logic              src_valid,
  input  logic [15:0]       src_data
);
  import atapi_pio_pkg::*;

  localparam int REM_W = 16 + BLK_LG;

  phase_t             ph_q;
  logic [6:0]         lim_lo_q;
  logic [7:0]         lim_hi_q;
  logic [14:0]        limw_q;
  logic [REM_W-1:0]   rem_q;
  logic [REM_W-1:0]   woff_q;
  logic [SRC_AW-1:0]  base_q;
  logic [BUF_LG:0]    fidx_q;
  logic [BUF_LG:0]    ridx_q;
  logic [BUF_LG:0]    xlen_q;
  logic [BUF_LG:0]    burst_w;
  logic               pend_q;
  logic               intr_q;
  logic               src_req_q;
  logic [SRC_AW-1:0]  src_addr_q;
  logic               rsel_q;
  logic [15:0]        rhold_q;
  logic [15:0]        ram_q;
  logic [7:0]         stat_c;

  logic wr_data, wr_cmd, rd_data, rd_stat;
  logic pkt_done;
  logic [31:0] pkt_lba;
  logic [15:0] pkt_cnt;
  logic fill_we, last_fill, xfer_rd, last_rd, raise;

  assign wr_data = host_wr && (host_addr == A_DATA);
  assign wr_cmd  = host_wr && (host_addr == A_CMD);
  assign rd_data = host_rd && (host_addr == A_DATA);
  assign rd_stat = host_rd && (host_addr == A_CMD);

  always_comb begin
    stat_c = '0;
    stat_c[ST_DRDY] = 1'b1;
    case (ph_q)
      PH_CMD, PH_FETCH: stat_c[ST_BSY] = 1'b1;
      PH_PKT, PH_XFER:  stat_c[ST_DRQ] = 1'b1;
      default: ;
    endcase
  end

  atapi_pkt_capture u_pkt (
    .clk   (clk),
    .rst   (rst),
    .clear (ph_q == PH_CMD),
    .wr    (wr_data && (ph_q == PH_PKT)),
    .wdata (host_wdata),
    .done  (pkt_done),
    .lba   (pkt_lba),
    .cnt   (pkt_cnt)
  );

  atapi_burst_plan #(.REM_W(REM_W), .BUF_LG(BUF_LG)) u_plan (
    .rem       (rem_q),
    .lim_words (limw_q),
    .words     (burst_w)
  );

  assign fill_we   = src_valid && pend_q && (ph_q == PH_FETCH);
  assign last_fill = fill_we && ((fidx_q + 1'b1) == burst_w);
  assign xfer_rd   = rd_data && (ph_q == PH_XFER);
  assign last_rd   = xfer_rd && ((ridx_q + 1'b1) == xlen_q);
  assign raise     = (pkt_done && (pkt_cnt == 16'd0)) || last_fill ||
                     (last_rd && (rem_q == '0));

  atapi_burst_buf #(.DW(16), .AW(BUF_LG)) u_buf (
    .clk   (clk),
    .we    (fill_we),
    .waddr (fidx_q[BUF_LG-1:0]),
    .wdata (src_data),
    .re    (xfer_rd),
    .raddr (ridx_q[BUF_LG-1:0]),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= PH_IDLE;
      lim_lo_q   <= '0;
      lim_hi_q   <= '0;
      limw_q     <= '0;
      rem_q      <= '0;
      woff_q     <= '0;
      base_q     <= '0;
      fidx_q     <= '0;
      ridx_q     <= '0;
      xlen_q     <= '0;
      pend_q     <= 1'b0;
      src_req_q  <= 1'b0;
      src_addr_q <= '0;
    end else begin
      src_req_q <= 1'b0;
      if (host_wr && (host_addr == A_LIM_LO)) lim_lo_q <= host_wdata[7:1];
      if (host_wr && (host_addr == A_LIM_HI)) lim_hi_q <= host_wdata[7:0];
      case (ph_q)
        PH_IDLE: begin
          if (wr_cmd && (host_wdata[7:0] == OP_PACKET)) begin
            limw_q <= {lim_hi_q, lim_lo_q};
            ph_q   <= PH_CMD;
          end
        end
        PH_CMD: ph_q <= PH_PKT;
        PH_PKT: begin
          if (pkt_done) begin
            if (pkt_cnt == 16'd0) begin
              ph_q <= PH_IDLE;
            end else begin
              rem_q  <= REM_W'(pkt_cnt) << BLK_LG;
              base_q <= SRC_AW'(pkt_lba) << BLK_LG;
              woff_q <= '0;
              fidx_q <= '0;
              pend_q <= 1'b0;
              ph_q   <= PH_FETCH;
            end
          end
        end
        PH_FETCH: begin
          if (!pend_q) begin
            src_req_q  <= 1'b1;
            src_addr_q <= base_q + SRC_AW'(woff_q);
            woff_q     <= woff_q + 1'b1;
            pend_q     <= 1'b1;
          end
          if (fill_we) begin
            fidx_q <= fidx_q + 1'b1;
            pend_q <= 1'b0;
            if (last_fill) begin
              xlen_q <= burst_w;
              rem_q  <= rem_q - REM_W'(burst_w);
              ridx_q <= '0;
              ph_q   <= PH_XFER;
            end
          end
        end
        PH_XFER: begin
          if (xfer_rd) begin
            ridx_q <= ridx_q + 1'b1;
            if (last_rd) begin
              fidx_q <= '0;
              ph_q   <= (rem_q == '0) ? PH_IDLE : PH_FETCH;
            end
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // raise has priority over the clear caused by a status read
  always_ff @(posedge clk) begin
    if (rst) intr_q <= 1'b0;
    else if (raise) intr_q <= 1'b1;
    else if (rd_stat) intr_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q  <= 1'b0;
      rhold_q <= '0;
    end else if (host_rd) begin
      rsel_q  <= xfer_rd;
      rhold_q <= rd_stat ? {8'h00, stat_c} : 16'h0000;
    end
  end

  assign host_rdata = rsel_q ? ram_q : rhold_q;
  assign intrq      = intr_q;
  assign src_req    = src_req_q;
  assign src_addr   = src_addr_q;
endmodule

// File: rtl/atapi_pio_chk.sv
module atapi_pio_chk (
  input logic        clk,
  input logic        rst,
  input logic        host_rd,
  input logic [2:0]  host_addr,
  input logic [15:0] host_rdata,
  input logic        intrq,
  input logic        src_req,
  input logic        bsy,
  input logic        drq
);
  // R11
  bsy_drq_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bsy && drq));

  // R11
  req_under_bsy_chk: assert property (@(posedge clk) disable iff (rst)
    src_req |-> bsy);

  // R9
  zero_data_read_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && (host_addr == 3'd0) && !drq) |=> (host_rdata == 16'h0000));

  // R8
  intr_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(intrq) |-> $past(host_rd && (host_addr == 3'd7)));

  // R8
  intr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (intrq && !(host_rd && (host_addr == 3'd7))) |=> intrq);
endmodule

bind atapi_pio_ctrl atapi_pio_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .host_rd    (host_rd),
  .host_addr  (host_addr),
  .host_rdata (host_rdata),
  .intrq      (intrq),
  .src_req    (src_req),
  .bsy        (stat_c[7]),
  .drq        (stat_c[3])
);

// File: tb/test_atapi_pio_ctrl.sv
module test_atapi_pio_ctrl;
  localparam int SRC_AW = 42;
  localparam int BUF_WORDS = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0;
  logic host_rd = 1'b0;
  logic [2:0] host_addr = 3'd0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic intrq;
  logic src_req;
  logic [SRC_AW-1:0] src_addr;
  logic src_valid;
  logic [15:0] src_data;

  int n_chk = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  bit irq_prev = 1'b0;
  bit want_data = 1'b0;
  bit mon_arm = 1'b0;
  bit finished = 1'b0;
  logic [15:0] exp_q [$];

  always #2 clk = ~clk;

  atapi_pio_ctrl i_atapi_pio_ctrl (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .intrq(intrq), .src_req(src_req), .src_addr(src_addr),
    .src_valid(src_valid), .src_data(src_data)
  );

  function automatic logic [15:0] pat(input logic [SRC_AW-1:0] a);
    return a[15:0] ^ {a[41:34], a[25:18]} ^ 16'hC35A;
  endfunction

  // block source model: two-cycle latency
  logic sv1, sv2;
  logic [SRC_AW-1:0] sa1, sa2;
  always @(posedge clk) begin
    if (rst) begin
      sv1 <= 1'b0; sv2 <= 1'b0; sa1 <= '0; sa2 <= '0;
    end else begin
      sv1 <= src_req; sa1 <= src_addr; sv2 <= sv1; sa2 <= sa1;
    end
  end
  assign src_valid = sv2;
  assign src_data  = pat(sa2);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: interrupt edges and scoreboard of data words
  always @(posedge clk) mon_arm <= host_rd && (host_addr == 3'd0) && want_data;
  always @(negedge clk) begin
    if (intrq && !irq_prev) irq_cnt++;
    irq_prev = intrq;
    if (mon_arm) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected data word", host_rdata, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(host_rdata == e, "R3/R4 data word", host_rdata, e);
      end
    end
  end

  // host tasks start and end on a falling edge
  task automatic hwr(input logic [2:0] a, input logic [15:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [15:0] d);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_irq(input string tag);
    int k = 0;
    while (!intrq && k < 20000) begin
      @(negedge clk);
      k++;
    end
    chk(intrq == 1'b1, tag, intrq, 1);
  endtask

  task automatic poll_until(input logic [7:0] want, input string tag);
    logic [7:0] s = 8'h00;
    int k = 0;
    host_rd = 1'b1; host_addr = 3'd7;
    while (k < 20000) begin
      @(negedge clk);
      s = host_rdata[7:0];
      if ((s & 8'h88) == 8'h88) chk(1'b0, "R11 BSY with DRQ", s, 8'h48);
      if (s == want) break;
      k++;
    end
    host_rd = 1'b0;
    chk(s == want, tag, s, want);
  endtask

  task automatic run_cmd(input logic [31:0] lba, input logic [15:0] cnt,
                         input logic [15:0] limit, input bit poll);
    logic [15:0] d;
    int limw, rem, off, bursts, base_irq;
    base_irq = irq_cnt;
    hwr(3'd4, {8'h00, limit[7:0]});
    hwr(3'd5, {8'h00, limit[15:8]});
    hwr(3'd7, 16'h00A0);
    hrd(3'd7, d);
    chk(d == 16'h00C0, "R2 busy after PACKET", d, 16'h00C0);
    hrd(3'd7, d);
    chk(d == 16'h0048, "R2 packet DRQ", d, 16'h0048);
    chk(intrq == 1'b0, "R2 no packet interrupt", intrq, 0);
    hwr(3'd0, 16'h0028);
    hwr(3'd0, {lba[23:16], lba[31:24]});
    hwr(3'd0, {lba[7:0], lba[15:8]});
    hwr(3'd0, {cnt[15:8], 8'h00});
    hwr(3'd0, {8'h00, cnt[7:0]});
    hwr(3'd0, 16'h0000);
    limw = int'(limit[15:1]);
    if (limw == 0) limw = 1;
    if (limw > BUF_WORDS) limw = BUF_WORDS;
    rem = int'(cnt) * 1024;
    off = 0;
    bursts = 0;
    if (cnt != 16'd0) begin
      hrd(3'd0, d);
      chk(d == 16'h0000, "R9 data read while fetching", d, 0);
      hrd(3'd7, d);
      chk(d == 16'h00C0, "R9 busy while fetching", d, 16'h00C0);
    end
    while (rem > 0) begin
      int n = (rem < limw) ? rem : limw;
      if (poll) poll_until(8'h48, "R6 burst DRQ (polled)");
      else begin
        wait_irq("R6 burst interrupt");
        hrd(3'd7, d);
        chk(d == 16'h0048, "R6 burst status", d, 16'h0048);
        chk(intrq == 1'b0, "R8 status read clears", intrq, 0);
      end
      for (int k = 0; k < n; k++)
        exp_q.push_back(pat({lba, 10'd0} + SRC_AW'(off + k)));
      want_data = 1'b1;
      for (int k = 0; k < n; k++) hrd(3'd0, d);
      want_data = 1'b0;
      @(negedge clk);
      off += n;
      rem -= n;
      bursts++;
    end
    if (poll) poll_until(8'h40, "R7 completion (polled)");
    else begin
      wait_irq("R7 completion interrupt");
      hrd(3'd7, d);
      chk(d == 16'h0040, "R7 completion status", d, 16'h0040);
      chk(intrq == 1'b0, "R8 completion cleared", intrq, 0);
    end
    chk(irq_cnt - base_irq == bursts + 1, "R5/R8 interrupt count",
        irq_cnt - base_irq, bursts + 1);
    chk(exp_q.size() == 0, "R4 all words delivered", exp_q.size(), 0);
  endtask

  initial begin
    logic [15:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(intrq == 1'b0, "R1 reset interrupt", intrq, 0);
    hrd(3'd7, d);
    chk(d == 16'h0040, "R1 reset status", d, 16'h0040);
    hwr(3'd7, 16'h00EC);
    hrd(3'd7, d);
    chk(d == 16'h0040, "R2 other command ignored", d, 16'h0040);
    chk(intrq == 1'b0, "R2 other command no interrupt", intrq, 0);
    // R5 limit 1000 bytes: bursts of 500, 500, 24 words
    run_cmd(32'd5, 16'd1, 16'd1000, 1'b0);
    // R8 odd limit 513, continuous polling to meet the raise edge
    run_cmd(32'h0001_2345, 16'd2, 16'h0201, 1'b1);
    // R10 zero count
    run_cmd(32'd7, 16'd0, 16'd100, 1'b0);
    hrd(3'd7, d);
    chk(d == 16'h0040, "R10 idle after zero count", d, 16'h0040);
    // R5 large limit clamped to buffer depth
    run_cmd(32'd2, 16'd3, 16'hFFFE, 1'b0);
    // R5 limit 1 byte clamped to one word per burst
    run_cmd(32'd9, 16'd1, 16'd1, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R4 actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule